// File: doc/BRIEF.md
# Bounds-Checked Array Load Unit

This unit executes two load operations for a small in-order core. Both work with an array descriptor held in a pair of adjacent registers: the even register holds the array's base byte address and the odd register above it holds the element count.

The checked load takes a destination register, the even descriptor register and an index operand. In the issue cycle it reads both halves of the descriptor through two register-file read ports. It sends the memory read for `base + (index << ELEM_SHIFT)` and, in the same cycle, compares the index with the count. One cycle later the result arrives. The loaded word is written back, or the unit raises a trap and drops the writeback.

The descriptor load reads two consecutive memory words from an address aligned to two words. It writes them into the register pair in a single writeback. Because of the alignment, both words always fall in the same page.

Top module: `chkld_unit`

## Requirements
- R1: In the issue cycle, `rfAddrBase` equals `issueDesc` and `rfAddrLen` equals `issueDesc` with bit 0 set.
- R2: A checked load (`issueOp`=0) with an even `issueDesc` asserts `memReq` in its issue cycle with `memAddr` = base + (`issueOperand` << ELEM_SHIFT) modulo 2^XLEN. This holds whether or not the index is in range, because the read runs in parallel with the check.
- R3: A checked load whose index, taken as unsigned, is below the count gives `wbEn`=1, `wbPair`=0, `wbAddr`=`issueDst` and `wbData` = low word of `memRdata` in the cycle after issue.
- R4: A checked load whose unsigned index is at or above the count gives `trapValid`=1 with `trapCause`=1 (bounds) in the cycle after issue, and `wbEn`=0. This includes a count of zero and a negative index.
- R5: A descriptor load (`issueOp`=1) with an even `issueDesc` and `issueOperand` aligned to two words asserts `memReq` with `memAddr`=`issueOperand`. In the next cycle it gives `wbEn`=1, `wbPair`=1, `wbAddr`=`issueDesc`, `wbData` = the word at the address and `wbDataHi` = the word after it.
- R6: A descriptor load whose `issueOperand` has any of its low log2(2·XLEN/8) bits set sends no memory read. In the next cycle it gives `trapValid`=1, `trapCause`=2 (misaligned) and no writeback.
- R7: An odd `issueDesc` on either operation sends no memory read. In the next cycle it gives `trapValid`=1, `trapCause`=3 (illegal) and no writeback. This check takes priority over the bounds and alignment checks.
- R8: During reset and in any cycle after a cycle without `issueValid`, `wbEn` and `trapValid` are both low, so a trap lasts one cycle per faulting issue.
- R9: Both operations have the same one-cycle latency, and issues in consecutive cycles each complete in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An operation is issued this cycle |
| issueOp | input | 1 | 0 = checked load, 1 = descriptor load |
| issueDst | input | log2(NREG) | Destination register of a checked load |
| issueDesc | input | log2(NREG) | Even register of the descriptor pair |
| issueOperand | input | XLEN | Index (checked load) or byte address (descriptor load) |
| rfAddrBase | output | log2(NREG) | Read port A address (base) |
| rfAddrLen | output | log2(NREG) | Read port B address (count) |
| rfDataBase | input | XLEN | Read port A data |
| rfDataLen | input | XLEN | Read port B data |
| memReq | output | 1 | Memory read request |
| memAddr | output | XLEN | Byte address of the read |
| memRdata | input | 2*XLEN | Word at memAddr (low half) and the next word (high half), valid the cycle after the request |
| wbEn | output | 1 | Writeback valid |
| wbPair | output | 1 | Writeback also targets wbAddr+1 |
| wbAddr | output | log2(NREG) | Writeback register |
| wbData | output | XLEN | Data for wbAddr |
| wbDataHi | output | XLEN | Data for wbAddr+1 when wbPair |
| trapValid | output | 1 | Trap raised |
| trapCause | output | 2 | 1 bounds, 2 misaligned, 3 illegal register |

## Verification
The bench builds the unit with XLEN=32, ELEM_SHIFT=2 and NREG=16. A 16-entry file makes the top register r15 reachable, so the illegal case for the last register index is covered. A 32-bit operand makes it easy to hit the unsigned wrap of a negative index and the address wrap of a large scaled index. It also drives the boundary indices (count−1, count, zero count) and each misaligned offset class, and runs all operation kinds back to back.

// File: rtl/chkld_pkg.sv
package chkld_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE    = 2'd0,
    TRAP_BOUNDS  = 2'd1,
    TRAP_ALIGN   = 2'd2,
    TRAP_ILLEGAL = 2'd3
  } trapCause_e;

  typedef enum logic {
    OP_CHECKED = 1'b0,
    OP_DESC    = 1'b1
  } loadOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic stageLoad;  // capture writeback target
    logic selPair;    // descriptor load selected
  } ctrlStrobe_t;
endpackage

// File: rtl/chkld_ctrl.sv
module chkld_ctrl
  import chkld_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  logic        issueOp,
  input  logic        idxInRange,
  input  logic        pairAligned,
  input  logic        descOdd,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        wbEn,
  output logic        wbPair,
  output logic        trapValid,
  output logic [1:0]  trapCause
);
  loadOp_e    opDec;
  trapCause_e causeNow;
  trapCause_e causeQ;
  logic       validQ;
  logic       pairQ;

  assign opDec = loadOp_e'(issueOp);

  // fault decode, illegal register has priority
  always_comb begin
    causeNow = TRAP_NONE;
    if (issueValid) begin
      if (descOdd)
        causeNow = TRAP_ILLEGAL;
      else if (opDec == OP_DESC && !pairAligned)
        causeNow = TRAP_ALIGN;
      else if (opDec == OP_CHECKED && !idxInRange)
        causeNow = TRAP_BOUNDS;
    end
  end

  // the read is sent before the bounds verdict is known
  assign memReq = issueValid && !descOdd && (opDec == OP_CHECKED || pairAligned);

  assign strobe.stageLoad = issueValid;
  assign strobe.selPair   = (opDec == OP_DESC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      causeQ <= TRAP_NONE;
      pairQ  <= 1'b0;
    end else begin
      validQ <= issueValid;
      causeQ <= causeNow;
      pairQ  <= issueValid && (opDec == OP_DESC);
    end
  end

  assign wbEn      = validQ && (causeQ == TRAP_NONE);
  assign wbPair    = wbEn && pairQ;
  assign trapValid = validQ && (causeQ != TRAP_NONE);
  assign trapCause = causeQ;
endmodule

// File: rtl/chkld_dpath.sv
module chkld_dpath
  import chkld_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int RA         = 5,
  parameter int ELEM_SHIFT = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [RA-1:0]   issueDst,
  input  logic [RA-1:0]   issueDesc,
  input  logic [XLEN-1:0] issueOperand,
  output logic [RA-1:0]   rfAddrBase,
  output logic [RA-1:0]   rfAddrLen,
  input  logic [XLEN-1:0] rfDataBase,
  input  logic [XLEN-1:0] rfDataLen,
  output logic [XLEN-1:0] memAddr,
  input  logic [2*XLEN-1:0] memRdata,
  output logic            idxInRange,
  output logic            pairAligned,
  output logic            descOdd,
  output logic [RA-1:0]   wbAddr,
  output logic [XLEN-1:0] wbData,
  output logic [XLEN-1:0] wbDataHi
);
  localparam int WORD_BYTES = XLEN / 8;
  localparam int PAIR_BITS  = $clog2(2 * WORD_BYTES);

  logic [XLEN-1:0] scaledIdx;
  logic [XLEN-1:0] elemAddr;
  logic [RA-1:0]   dstQ;

  assign rfAddrBase = issueDesc;
  assign rfAddrLen  = {issueDesc[RA-1:1], 1'b1};
  assign descOdd    = issueDesc[0];

  // address path and bounds compare side by side
  assign scaledIdx   = issueOperand << ELEM_SHIFT;
  assign elemAddr    = rfDataBase + scaledIdx;
  assign idxInRange  = issueOperand < rfDataLen;
  assign pairAligned = (issueOperand[PAIR_BITS-1:0] == '0);
  assign memAddr     = strobe.selPair ? issueOperand : elemAddr;

  always_ff @(posedge clk) begin
    if (!rstN)
      dstQ <= '0;
    else if (strobe.stageLoad)
      dstQ <= strobe.selPair ? issueDesc : issueDst;
  end

  assign wbAddr   = dstQ;
  assign wbData   = memRdata[XLEN-1:0];
  assign wbDataHi = memRdata[2*XLEN-1:XLEN];
endmodule

// File: rtl/chkld_unit.sv
module chkld_unit
  import chkld_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREG       = 32,
  parameter int ELEM_SHIFT = 2,
  localparam int RA        = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              issueOp,
  input  logic [RA-1:0]     issueDst,
  input  logic [RA-1:0]     issueDesc,
  input  logic [XLEN-1:0]   issueOperand,
  output logic [RA-1:0]     rfAddrBase,
  output logic [RA-1:0]     rfAddrLen,
  input  logic [XLEN-1:0]   rfDataBase,
  input  logic [XLEN-1:0]   rfDataLen,
  output logic              memReq,
  output logic [XLEN-1:0]   memAddr,
  input  logic [2*XLEN-1:0] memRdata,
  output logic              wbEn,
  output logic              wbPair,
  output logic [RA-1:0]     wbAddr,
  output logic [XLEN-1:0]   wbData,
  output logic [XLEN-1:0]   wbDataHi,
  output logic              trapValid,
  output logic [1:0]        trapCause
);
  ctrlStrobe_t strobe;
  logic idxInRange;
  logic pairAligned;
  logic descOdd;

  chkld_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueOp    (issueOp),
    .idxInRange (idxInRange),
    .pairAligned(pairAligned),
    .descOdd    (descOdd),
    .strobe     (strobe),
    .memReq     (memReq),
    .wbEn       (wbEn),
    .wbPair     (wbPair),
    .trapValid  (trapValid),
    .trapCause  (trapCause)
  );

  chkld_dpath #(
    .XLEN      (XLEN),
    .RA        (RA),
    .ELEM_SHIFT(ELEM_SHIFT)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .issueDst    (issueDst),
    .issueDesc   (issueDesc),
    .issueOperand(issueOperand),
    .rfAddrBase  (rfAddrBase),
    .rfAddrLen   (rfAddrLen),
    .rfDataBase  (rfDataBase),
    .rfDataLen   (rfDataLen),
    .memAddr     (memAddr),
    .memRdata    (memRdata),
    .idxInRange  (idxInRange),
    .pairAligned (pairAligned),
    .descOdd     (descOdd),
    .wbAddr      (wbAddr),
    .wbData      (wbData),
    .wbDataHi    (wbDataHi)
  );
endmodule

// File: rtl/chkld_checker.sv
module chkld_checker #(
  parameter int XLEN = 32,
  parameter int RA   = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            issueValid,
  input logic            issueOp,
  input logic [RA-1:0]   issueDesc,
  input logic [XLEN-1:0] issueOperand,
  input logic            memReq,
  input logic            wbEn,
  input logic            wbPair,
  input logic [RA-1:0]   wbAddr,
  input logic            trapValid
);
  localparam int PAIR_BITS = $clog2(2 * (XLEN / 8));

  // R7: odd descriptor register never reaches memory
  p_no_read_illegal_r7: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueDesc[0]) |-> !memReq);

  // R6: misaligned descriptor load never reaches memory
  p_no_read_misaligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueOp && (issueOperand[PAIR_BITS-1:0] != '0)) |-> !memReq);

  // R4: a trap never comes with a writeback
  p_no_wb_on_trap_r4: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> !wbEn);

  // R9: every issue resolves exactly one cycle later
  p_one_cycle_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> (wbEn || trapValid));

  // R8: nothing comes out after an idle cycle
  p_quiet_after_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> (!wbEn && !trapValid));

  // R2: every memory read yields a result next cycle
  p_read_resolves_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> (wbEn || trapValid));

  // R5: a pair writeback targets an even register
  p_pair_even_r5: assert property (@(posedge clk) disable iff (!rstN)
    wbPair |-> (wbEn && !wbAddr[0]));
endmodule

bind chkld_unit chkld_checker #(.XLEN(XLEN), .RA(RA)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .issueValid  (issueValid),
  .issueOp     (issueOp),
  .issueDesc   (issueDesc),
  .issueOperand(issueOperand),
  .memReq      (memReq),
  .wbEn        (wbEn),
  .wbPair      (wbPair),
  .wbAddr      (wbAddr),
  .trapValid   (trapValid)
);

// File: tb/test_chkld_unit.sv
module test_chkld_unit;
  localparam int XLEN = 32;
  localparam int NREG = 16;
  localparam int ES   = 2;
  localparam int RA   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic issueOp = 1'b0;
  logic [RA-1:0] issueDst = '0;
  logic [RA-1:0] issueDesc = '0;
  logic [XLEN-1:0] issueOperand = '0;
  logic [RA-1:0] rfAddrBase, rfAddrLen;
  logic [XLEN-1:0] rfDataBase, rfDataLen;
  logic memReq;
  logic [XLEN-1:0] memAddr;
  logic [2*XLEN-1:0] memRdata = '0;
  logic wbEn, wbPair, trapValid;
  logic [RA-1:0] wbAddr;
  logic [XLEN-1:0] wbData, wbDataHi;
  logic [1:0] trapCause;

  logic [XLEN-1:0] rf [NREG];
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  typedef struct {
    bit isTrap;
    bit pair;
    logic [RA-1:0] addr;
    logic [XLEN-1:0] lo;
    logic [XLEN-1:0] hi;
    logic [1:0] cause;
    string req;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;

  assign rfDataBase = rf[rfAddrBase];
  assign rfDataLen  = rf[rfAddrLen];

  function automatic logic [XLEN-1:0] memWord(logic [XLEN-1:0] a);
    return (a * 32'd3) ^ 32'h1357_0000;
  endfunction

  always @(posedge clk)
    if (memReq) memRdata <= {memWord(memAddr + 32'd4), memWord(memAddr)};

  chkld_unit #(.XLEN(XLEN), .NREG(NREG), .ELEM_SHIFT(ES)) i_chkld_unit (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .issueDst(issueDst), .issueDesc(issueDesc), .issueOperand(issueOperand),
    .rfAddrBase(rfAddrBase), .rfAddrLen(rfAddrLen),
    .rfDataBase(rfDataBase), .rfDataLen(rfDataLen),
    .memReq(memReq), .memAddr(memAddr), .memRdata(memRdata),
    .wbEn(wbEn), .wbPair(wbPair), .wbAddr(wbAddr), .wbData(wbData),
    .wbDataHi(wbDataHi), .trapValid(trapValid), .trapCause(trapCause));

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: apply one issue, check issue-cycle outputs, push expectation
  task automatic issue(bit op, logic [RA-1:0] dst, logic [RA-1:0] desc,
                       logic [XLEN-1:0] opnd, string req);
    exp_t e;
    bit expReq;
    logic [XLEN-1:0] expAddr;
    @(negedge clk);
    issueValid = 1'b1; issueOp = op; issueDst = dst;
    issueDesc = desc; issueOperand = opnd;
    e.req = req; e.pair = 1'b0; e.isTrap = 1'b0; e.cause = 2'd0;
    e.addr = dst; e.lo = '0; e.hi = '0;
    expAddr = '0;
    if (desc[0]) begin
      expReq = 1'b0; e.isTrap = 1'b1; e.cause = 2'd3;
    end else if (op) begin
      if (opnd[2:0] != 3'd0) begin
        expReq = 1'b0; e.isTrap = 1'b1; e.cause = 2'd2;
      end else begin
        expReq = 1'b1; expAddr = opnd;
        e.pair = 1'b1; e.addr = desc;
        e.lo = memWord(opnd); e.hi = memWord(opnd + 32'd4);
      end
    end else begin
      expReq = 1'b1;
      expAddr = rf[desc] + (opnd << ES);
      if (opnd < rf[{desc[RA-1:1], 1'b1}]) e.lo = memWord(expAddr);
      else begin e.isTrap = 1'b1; e.cause = 2'd1; end
    end
    expQ.push_back(e);
    #1;
    chk(rfAddrBase == desc, "R1", "rfAddrBase", 64'(rfAddrBase), 64'(desc));
    chk(rfAddrLen == {desc[RA-1:1], 1'b1}, "R1", "rfAddrLen",
        64'(rfAddrLen), 64'({desc[RA-1:1], 1'b1}));
    chk(memReq == expReq, req, "memReq", 64'(memReq), 64'(expReq));
    if (expReq) chk(memAddr == expAddr, "R2", "memAddr", 64'(memAddr), 64'(expAddr));
  endtask

  task automatic idle();
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  // monitor: pop and compare one result per cycle
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #3;
      if (!rstN) continue;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        if (e.isTrap) begin
          chk(trapValid == 1'b1, e.req, "trapValid", 64'(trapValid), 64'd1);
          chk(trapCause == e.cause, e.req, "trapCause", 64'(trapCause), 64'(e.cause));
          chk(wbEn == 1'b0, e.req, "wbEn on trap", 64'(wbEn), 64'd0);
        end else begin
          chk(wbEn == 1'b1 && trapValid == 1'b0, e.req, "wbEn/trapValid",
              64'({wbEn, trapValid}), 64'd2);
          chk(wbPair == e.pair, e.req, "wbPair", 64'(wbPair), 64'(e.pair));
          chk(wbAddr == e.addr, e.req, "wbAddr", 64'(wbAddr), 64'(e.addr));
          chk(wbData == e.lo, e.req, "wbData", 64'(wbData), 64'(e.lo));
          if (e.pair) chk(wbDataHi == e.hi, e.req, "wbDataHi", 64'(wbDataHi), 64'(e.hi));
        end
      end else begin
        chk(!wbEn && !trapValid, "R8", "idle outputs", 64'({wbEn, trapValid}), 64'd0);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) rf[i] = 32'h0;
    rf[2] = 32'h0000_1000; rf[3] = 32'd8;
    rf[4] = 32'h0000_2000; rf[5] = 32'd0;
    rf[6] = 32'hFFFF_FF00; rf[7] = 32'hFFFF_FFFF;
    rf[14] = 32'h0000_5000; rf[15] = 32'd4;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!wbEn && !trapValid && !memReq, "R8", "reset outputs",
        64'({wbEn, trapValid, memReq}), 64'd0);
    rstN = 1'b1;
    idle();
    // R3: first and last in-range index
    issue(1'b0, 4'd9, 4'd2, 32'd0, "R3");
    issue(1'b0, 4'd10, 4'd2, 32'd7, "R3");
    // R4: index equal to count, negative index, zero count
    issue(1'b0, 4'd9, 4'd2, 32'd8, "R4");
    issue(1'b0, 4'd9, 4'd2, 32'hFFFF_FFFF, "R4");
    issue(1'b0, 4'd9, 4'd4, 32'd0, "R4");
    idle();
    // R2: address wraps, large count in range
    issue(1'b0, 4'd11, 4'd6, 32'h0000_0100, "R2");
    // R5: aligned descriptor load
    issue(1'b1, 4'd0, 4'd8, 32'h0000_4000, "R5");
    issue(1'b1, 4'd0, 4'd12, 32'h0000_4008, "R5");
    // R6: misaligned by one word and by one byte
    issue(1'b1, 4'd0, 4'd8, 32'h0000_4004, "R6");
    issue(1'b1, 4'd0, 4'd8, 32'h0000_4001, "R6");
    idle();
    // R7: odd and last register, both ops; priority over bounds/alignment
    issue(1'b0, 4'd9, 4'd3, 32'd0, "R7");
    issue(1'b0, 4'd9, 4'd15, 32'd100, "R7");
    issue(1'b1, 4'd0, 4'd15, 32'h0000_4003, "R7");
    idle();
    idle();
    // R9: mixed back-to-back stream
    issue(1'b1, 4'd0, 4'd14, 32'h0000_6000, "R9");
    issue(1'b0, 4'd1, 4'd14, 32'd3, "R9");
    issue(1'b0, 4'd1, 4'd14, 32'd4, "R9");
    issue(1'b0, 4'd13, 4'd2, 32'd5, "R9");
    issue(1'b1, 4'd0, 4'd1, 32'h0000_6000, "R9");
    issue(1'b0, 4'd5, 4'd2, 32'd2, "R9");
    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule